// File: doc/BRIEF.md
# SDRAM Refresh and Power-State Scheduler

This block sits beside the command arbiter of an SDRAM controller. It keeps the periodic refresh going and drives the clock-enable low-power states. A free-running interval counter adds one owed refresh to a small backlog each time it expires. While the backlog is non-empty, the block asks the arbiter for the command bus and holds the request until the arbiter grants it. On a grant it closes all open banks if the arbiter reports any as open. It then issues Auto-Refresh and keeps the bus on NOP for the refresh cycle time, raising `busy` for the whole sequence.

The backlog saturates at a parameter limit. A backlog at that limit means the refresh deadline was missed. The next grant then issues two Auto-Refresh commands back to back, each followed by the full refresh cycle time, and clears the backlog.

The block also enters and leaves self-refresh and power-down when asked. During self-refresh the interval counter is frozen, and it restarts a full interval after the exit delay. Power-down is left on its own as soon as a refresh falls due.

Top module: `ref_pwr_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cke` is 1, `cmd` is NOP, `busy` is 0 and `refReq` is 0.
- R2: `refReq` rises `INTERVAL` clock edges after reset is released. It stays high until a grant retires the owed refresh. A `refGrant` pulse while `refReq` is low has no effect: `busy` stays 0 and `cmd` stays NOP.
- R3: If `banksIdle` is 1 when the grant is taken, Auto-Refresh appears in the next cycle. If `banksIdle` is 0, precharge-all appears in the next cycle and Auto-Refresh follows `RP_CYC` cycles after it. Only NOP follows an Auto-Refresh for `RFC_CYC` cycles. `busy` is high from the first command until `RFC_CYC` cycles after the last Auto-Refresh.
- R4: A grant on a backlog below `POSTPONE_MAX` issues one Auto-Refresh and retires one owed refresh. `refReq` stays high if more are owed. The backlog saturates at `POSTPONE_MAX`. A grant on a saturated backlog issues exactly two Auto-Refresh commands, `RFC_CYC` cycles apart, and leaves no refresh owed.
- R5: A self-refresh request in the idle state produces, one cycle later, Auto-Refresh with `cke` low in the same cycle. If `banksIdle` is 0, a precharge-all comes first and the entry follows `RP_CYC` cycles later. During self-refresh no refresh is owed, and the interval counter does not advance.
- R6: When the self-refresh request drops, `cke` returns high in the next cycle. `busy` then stays high for `RC_CYC+2` cycles. `refReq` rises `INTERVAL` cycles after `busy` falls.
- R7: A power-down request in the idle state with no owed refresh drives `cke` low with NOP and `busy` high from the next cycle on. Power-down is left when the request drops or when a refresh falls due. `cke` is high with `busy` high for one cycle before the idle state.
- R8: Whenever `cke` was already low in the previous cycle, `cmd` is NOP.
- R9: `cmd` is the row-strobe, column-strobe and write-enable levels, in that bit order (active low): NOP = 3'b111, precharge-all = 3'b010, Auto-Refresh = 3'b001. The memory's chip select is held active and its auto-precharge address bit high by the controller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous active-low reset |
| refGrant | input | 1 | Arbiter grants the command bus for refresh |
| banksIdle | input | 1 | All banks are precharged |
| selfRefReq | input | 1 | Level request to stay in self-refresh |
| pwrDownReq | input | 1 | Level request to stay in power-down |
| refReq | output | 1 | At least one refresh is owed |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | Command levels {ras, cas, we}, active low |
| busy | output | 1 | Block owns the command bus; arbiter must issue nothing |

## Verification
The hardest state to reach is the missed deadline. The arbiter has to withhold the grant through `POSTPONE_MAX` whole intervals and then grant exactly once, and the two refreshes have to finish before the next interval expires. With small bench parameters the stimulus table does this by waiting a computed number of intervals plus two cycles before each grant. It includes one case that waits past saturation, to show that the backlog stops counting. A second hard case is power-down left by a refresh falling due. The bench holds the power-down request past one interval and checks that the clock enable comes back on its own.

// File: rtl/ref_pwr_pkg.sv
package ref_pwr_pkg;
  timeunit 1ns; timeprecision 1ps;

  // {rasN, casN, weN}
  typedef enum logic [2:0] {
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } sdCmd_t;

  typedef enum logic [1:0] {
    TMR_RP,
    TMR_RFC,
    TMR_EXIT
  } tmrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    runIvl;     // interval counter may advance
    logic    reloadIvl;  // restart the interval
    logic    retireOne;  // one owed refresh done
    logic    retireAll;  // backlog cleared
    logic    loadTmr;    // start the wait timer
    tmrSel_t tmrSel;     // which wait to start
  } dpStrobe_t;
endpackage

// File: rtl/ref_pwr_dp.sv
module ref_pwr_dp
  import ref_pwr_pkg::*;
#(
  parameter int INTERVAL     = 2343,
  parameter int POSTPONE_MAX = 8,
  parameter int RP_CYC       = 2,
  parameter int RFC_CYC      = 9,
  parameter int RC_CYC       = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t stb,
  output logic      pendNz,
  output logic      missed,
  output logic      tmrZero
);
  timeunit 1ns; timeprecision 1ps;

  localparam int IVL_W    = $clog2(INTERVAL);
  localparam int PEND_W   = $clog2(POSTPONE_MAX + 1);
  localparam int EXIT_CYC = RC_CYC + 2;
  localparam int TOP_A    = (RFC_CYC > RP_CYC) ? RFC_CYC : RP_CYC;
  localparam int TMR_TOP  = (EXIT_CYC > TOP_A) ? EXIT_CYC : TOP_A;
  localparam int TMR_W    = $clog2(TMR_TOP + 1);
  localparam logic [IVL_W-1:0]  IVL_LAST = IVL_W'(INTERVAL - 1);
  localparam logic [PEND_W-1:0] PEND_CAP = PEND_W'(POSTPONE_MAX);

  logic [IVL_W-1:0]  ivlCnt;
  logic [PEND_W-1:0] pending, afterRetire, pendNext;
  logic [TMR_W-1:0]  tmr, tmrLoadVal;
  logic              tick;

  assign tick = stb.runIvl && !stb.reloadIvl && (ivlCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || stb.reloadIvl) ivlCnt <= IVL_LAST;
    else if (stb.runIvl)        ivlCnt <= (ivlCnt == '0) ? IVL_LAST : ivlCnt - 1'b1;
  end

  always_comb begin
    if (stb.retireAll)                       afterRetire = '0;
    else if (stb.retireOne && pending != '0) afterRetire = pending - 1'b1;
    else                                     afterRetire = pending;
    pendNext = (tick && afterRetire != PEND_CAP) ? afterRetire + 1'b1 : afterRetire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= pendNext;
  end

  assign pendNz = (pending != '0);
  assign missed = (pending == PEND_CAP);

  always_comb begin
    unique case (stb.tmrSel)
      TMR_RP:   tmrLoadVal = TMR_W'(RP_CYC - 2);
      TMR_RFC:  tmrLoadVal = TMR_W'(RFC_CYC - 2);
      default:  tmrLoadVal = TMR_W'(EXIT_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            tmr <= '0;
    else if (stb.loadTmr) tmr <= tmrLoadVal;
    else if (tmr != '0)   tmr <= tmr - 1'b1;
  end

  assign tmrZero = (tmr == '0);
endmodule

// File: rtl/ref_pwr_ctrl.sv
module ref_pwr_ctrl
  import ref_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      refGrant,
  input  logic      banksIdle,
  input  logic      selfRefReq,
  input  logic      pwrDownReq,
  input  logic      pendNz,
  input  logic      missed,
  input  logic      tmrZero,
  output dpStrobe_t stb,
  output logic      cke,
  output sdCmd_t    cmd,
  output logic      busy
);
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_PRE_WAIT, ST_REF, ST_REF_WAIT,
    ST_SR_ENTER, ST_SR, ST_SR_EXIT, ST_PD, ST_PD_EXIT
  } state_t;

  state_t state, nxt;
  logic   toSelf, dbl, secondLeft;
  logic   takeGrant;

  assign takeGrant = refGrant && pendNz;

  always_comb begin
    nxt        = state;
    stb        = '0;
    stb.runIvl = 1'b1;
    stb.tmrSel = TMR_RP;
    cke        = 1'b1;
    cmd        = CMD_NOP;
    unique case (state)
      ST_IDLE: begin
        if (takeGrant)                   nxt = banksIdle ? ST_REF : ST_PRE;
        else if (selfRefReq)             nxt = banksIdle ? ST_SR_ENTER : ST_PRE;
        else if (pwrDownReq && !pendNz)  nxt = ST_PD;
      end
      ST_PRE: begin
        cmd         = CMD_PRE;
        stb.loadTmr = 1'b1;
        stb.tmrSel  = TMR_RP;
        nxt         = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (tmrZero) nxt = toSelf ? ST_SR_ENTER : ST_REF;
      ST_REF: begin
        cmd           = CMD_REF;
        stb.loadTmr   = 1'b1;
        stb.tmrSel    = TMR_RFC;
        stb.retireAll = dbl;
        stb.retireOne = !dbl;
        nxt           = ST_REF_WAIT;
      end
      ST_REF_WAIT: if (tmrZero) nxt = secondLeft ? ST_REF : ST_IDLE;
      ST_SR_ENTER: begin
        cmd           = CMD_REF;
        cke           = 1'b0;
        stb.retireAll = 1'b1;
        stb.runIvl    = 1'b0;
        stb.reloadIvl = 1'b1;
        nxt           = ST_SR;
      end
      ST_SR: begin
        cke           = 1'b0;
        stb.runIvl    = 1'b0;
        stb.reloadIvl = 1'b1;
        if (!selfRefReq) begin
          stb.loadTmr = 1'b1;
          stb.tmrSel  = TMR_EXIT;
          nxt         = ST_SR_EXIT;
        end
      end
      ST_SR_EXIT: begin
        stb.runIvl    = 1'b0;
        stb.reloadIvl = 1'b1;
        if (tmrZero) nxt = ST_IDLE;
      end
      ST_PD: begin
        cke = 1'b0;
        if (!pwrDownReq || pendNz) nxt = ST_PD_EXIT;
      end
      ST_PD_EXIT: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      toSelf     <= 1'b0;
      dbl        <= 1'b0;
      secondLeft <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE) begin
        if (takeGrant) begin
          toSelf     <= 1'b0;
          dbl        <= missed;
          secondLeft <= missed;
        end else if (selfRefReq) begin
          toSelf <= 1'b1;
        end
      end
      if (state == ST_REF_WAIT && tmrZero) secondLeft <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ref_pwr_sched.sv
module ref_pwr_sched
  import ref_pwr_pkg::*;
#(
  parameter int INTERVAL     = 2343,
  parameter int POSTPONE_MAX = 8,
  parameter int RP_CYC       = 2,
  parameter int RFC_CYC      = 9,
  parameter int RC_CYC       = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  logic       banksIdle,
  input  logic       selfRefReq,
  input  logic       pwrDownReq,
  output logic       refReq,
  output logic       cke,
  output logic [2:0] cmd,
  output logic       busy
);
  timeunit 1ns; timeprecision 1ps;

  dpStrobe_t stb;
  sdCmd_t    cmdEnum;
  logic      pendNz, missed, tmrZero;

  ref_pwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .banksIdle(banksIdle),
    .selfRefReq(selfRefReq), .pwrDownReq(pwrDownReq), .pendNz(pendNz),
    .missed(missed), .tmrZero(tmrZero), .stb(stb), .cke(cke),
    .cmd(cmdEnum), .busy(busy)
  );

  ref_pwr_dp #(
    .INTERVAL(INTERVAL), .POSTPONE_MAX(POSTPONE_MAX), .RP_CYC(RP_CYC),
    .RFC_CYC(RFC_CYC), .RC_CYC(RC_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pendNz(pendNz), .missed(missed),
    .tmrZero(tmrZero)
  );

  assign refReq = pendNz;
  assign cmd    = cmdEnum;
endmodule

// File: rtl/ref_pwr_sva.sv
module ref_pwr_sva #(
  parameter int RFC_CYC = 9
) (
  input logic       clk,
  input logic       rstN,
  input logic       refGrant,
  input logic       selfRefReq,
  input logic       refReq,
  input logic       cke,
  input logic [2:0] cmd,
  input logic       busy
);
  timeunit 1ns; timeprecision 1ps;

  localparam int GAP_W = $clog2(RFC_CYC + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(RFC_CYC);

  logic [GAP_W-1:0] sinceRef;

  always_ff @(posedge clk) begin
    if (!rstN)                   sinceRef <= GAP_FULL;
    else if (cmd == 3'b001)      sinceRef <= GAP_W'(1);
    else if (sinceRef < GAP_FULL) sinceRef <= sinceRef + 1'b1;
  end

  // R3: no command within the refresh cycle time after Auto-Refresh
  p_ref_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != 3'b111) |-> (sinceRef >= GAP_FULL));

  // R2: owed refresh stays requested until taken
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGrant && !busy && !selfRefReq) |=> refReq);

  // R8: clock enable low means only NOP
  p_cke_low_nop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && $past(!cke)) |-> (cmd == 3'b111));

  // R6 / R7: a clock-enable return is covered by busy
  p_cke_rise_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> busy);

  // R1: idle bus carries NOP with clock enable high
  p_idle_nop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (cke && cmd == 3'b111));
endmodule

bind ref_pwr_sched ref_pwr_sva #(.RFC_CYC(RFC_CYC)) u_sva (
  .clk(clk), .rstN(rstN), .refGrant(refGrant), .selfRefReq(selfRefReq),
  .refReq(refReq), .cke(cke), .cmd(cmd), .busy(busy)
);

// File: tb/test_ref_pwr_sched.sv
module test_ref_pwr_sched;
  timeunit 1ns; timeprecision 1ps;

  localparam int B_IVL  = 16;
  localparam int B_PMAX = 3;
  localparam int B_RP   = 3;
  localparam int B_RFC  = 4;
  localparam int B_RC   = 5;
  localparam logic [2:0] NOP = 3'b111, PRE = 3'b010, REF = 3'b001;

  typedef struct packed {
    logic       idle;      // banksIdle at grant
    logic [3:0] ticks;     // intervals waited before grant
    logic [1:0] refs;      // expected Auto-Refresh count
    logic       reqAfter;  // refReq once busy falls
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 4'd1, 2'd1, 1'b0},
    '{1'b0, 4'd1, 2'd1, 1'b0},
    '{1'b1, 4'd2, 2'd1, 1'b1},
    '{1'b1, 4'd3, 2'd2, 1'b0},
    '{1'b0, 4'd3, 2'd2, 1'b0},
    '{1'b1, 4'd6, 2'd2, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic refGrant = 1'b0, banksIdle = 1'b1, selfRefReq = 1'b0, pwrDownReq = 1'b0;
  logic refReq, cke, busy;
  logic [2:0] cmd;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  ref_pwr_sched #(
    .INTERVAL(B_IVL), .POSTPONE_MAX(B_PMAX), .RP_CYC(B_RP),
    .RFC_CYC(B_RFC), .RC_CYC(B_RC)
  ) i_ref_pwr_sched (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .banksIdle(banksIdle),
    .selfRefReq(selfRefReq), .pwrDownReq(pwrDownReq), .refReq(refReq),
    .cke(cke), .cmd(cmd), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; refGrant = 1'b0; banksIdle = 1'b1;
    selfRefReq = 1'b0; pwrDownReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #750000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1 reset state, R9 NOP encoding
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 cke in reset", cke, 1);
    check("R9 cmd NOP in reset", cmd, NOP);
    check("R1 busy in reset", busy, 0);
    check("R1 refReq in reset", refReq, 0);
    doReset();
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 refReq after reset", refReq, 0);

    // R2 grant with nothing owed is ignored
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    check("R2 ignored grant busy", busy, 0);
    check("R2 ignored grant cmd", cmd, NOP);

    // R2 R3 R4 table of refresh services
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      int busyLen, nRef, nPre, firstRef, secondRef;
      v = VEC[i];
      doReset();
      repeat (B_IVL * v.ticks - 1) @(negedge clk);
      check("R2 no request before interval", refReq, (v.ticks == 1) ? 0 : 1);
      repeat (3) @(negedge clk);
      check("R2 request held", refReq, 1);
      banksIdle = v.idle;
      refGrant  = 1'b1;
      @(negedge clk);
      refGrant = 1'b0;
      check("R3 first command", cmd, v.idle ? REF : PRE);
      busyLen = 0; nRef = 0; nPre = 0; firstRef = -1; secondRef = -1;
      for (int n = 0; n < 30; n++) begin
        if (!busy) break;
        busyLen++;
        if (cmd == REF) begin
          nRef++;
          if (firstRef < 0) firstRef = n; else secondRef = n;
        end
        if (cmd == PRE) nPre++;
        @(negedge clk);
      end
      check("R3 busy length", busyLen, (v.idle ? 0 : B_RP) + int'(v.refs) * B_RFC);
      check("R4 refresh count", nRef, int'(v.refs));
      check("R3 precharge count", nPre, v.idle ? 0 : 1);
      check("R3 refresh position", firstRef, v.idle ? 0 : B_RP);
      if (v.refs == 2) check("R4 double spacing", secondRef - firstRef, B_RFC);
      check("R4 request after service", refReq, int'(v.reqAfter));
    end

    // R5 R6 R8 self-refresh with banks idle
    doReset();
    selfRefReq = 1'b1;
    @(negedge clk);
    check("R5 entry command", cmd, REF);
    check("R5 entry cke", cke, 0);
    @(negedge clk);
    check("R8 nop in self-refresh", cmd, NOP);
    repeat (40) @(negedge clk);
    check("R5 nothing owed while frozen", refReq, 0);
    check("R5 cke stays low", cke, 0);
    selfRefReq = 1'b0;
    @(negedge clk);
    check("R6 cke back high", cke, 1);
    begin
      int exitLen, k;
      exitLen = 0;
      for (int n = 0; n < 40; n++) begin
        if (!busy) break;
        exitLen++;
        @(negedge clk);
      end
      check("R6 exit busy length", exitLen, B_RC + 2);
      k = 0;
      for (int n = 0; n < 40; n++) begin
        if (refReq) break;
        k++;
        @(negedge clk);
      end
      check("R6 first request after exit", k, B_IVL);
    end

    // R5 self-refresh with open banks
    doReset();
    banksIdle  = 1'b0;
    selfRefReq = 1'b1;
    @(negedge clk);
    check("R5 precharge before entry", cmd, PRE);
    begin
      int pos;
      pos = 0;
      for (int n = 0; n < 20; n++) begin
        if (!cke) break;
        pos++;
        @(negedge clk);
      end
      check("R5 entry delay after precharge", pos, B_RP);
      check("R5 entry refresh", cmd, REF);
    end
    selfRefReq = 1'b0;
    repeat (B_RC + 4) @(negedge clk);
    check("R6 idle after exit", busy, 0);

    // R7 power-down by request
    doReset();
    pwrDownReq = 1'b1;
    @(negedge clk);
    check("R7 power-down cke", cke, 0);
    check("R7 power-down busy", busy, 1);
    check("R8 power-down nop", cmd, NOP);
    repeat (3) @(negedge clk);
    pwrDownReq = 1'b0;
    @(negedge clk);
    check("R7 exit cke", cke, 1);
    check("R7 exit busy", busy, 1);
    @(negedge clk);
    check("R7 idle after exit", busy, 0);

    // R7 power-down left when a refresh falls due
    doReset();
    pwrDownReq = 1'b1;
    repeat (B_IVL + 4) @(negedge clk);
    check("R7 auto exit cke", cke, 1);
    check("R7 auto exit request", refReq, 1);
    check("R7 no re-entry while owed", busy, 0);
    pwrDownReq = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule